// File: doc/BRIEF.md
# Operand Pair Collector and Arbiter

This block gathers operand pairs from several input rows and hands them, one pair at a time, to a single downstream consumer. Each row supplies two operand words. Each word has its own ready strobe. Once both strobes of a row are seen together, the row captures its pair and holds it as a pending request. The row then no longer depends on its inputs until that request has been forwarded.

The output side uses a strobe/acknowledge handshake. When no offer is open and at least one row is pending, the block opens an offer for the lowest-numbered pending row. While the offer is open the output data reads zero. One cycle after the consumer's acknowledge is sampled, several things happen together: the captured pair appears on the output data, the row index appears on the multiplex-ID output, the offer closes and that row's pending state clears. The next offer can open on the following edge.

Top module: `opnd_collect_arb`

## Requirements
- R1: A row captures its pair and becomes pending (its bit of `row_pend_o` set one edge later) only when both of its strobe bits are 1 (`2'b11`). Strobe patterns `2'b01` and `2'b10` leave `row_pend_o`, `out_stb_o` and `out_opnd_o` unchanged.
- R2: When `out_stb_o` is low and any row is pending, `out_stb_o` is high after the next clock edge.
- R3: While `out_stb_o` is high and the acknowledge has not yet taken effect, `out_opnd_o` reads all zeros.
- R4: If `out_ack_i` is high at an edge while `out_stb_o` is high, then after that edge `out_stb_o` is low. At the same time `out_opnd_o` holds the served row's pair, with operand 0 in bits [31:0] and operand 1 in bits [63:32], and `out_mid_o` holds the served row's index.
- R5: Among pending rows the lowest index is offered first. A row picked for an offer stays the offered row until it is accepted, even if a lower-indexed row becomes pending meanwhile.
- R6: A row's pending bit clears on the edge where its pair is accepted. Each captured pair is forwarded exactly once.
- R7: Dropping a row's strobes after capture does not cancel its pending request. A pending bit falls only through acceptance of that row, or through reset.
- R8: The captured pair is the operand value present on the capturing edge. Later changes of operands or strobes on a pending row are ignored.
- R9: A synchronous reset clears every pending bit, `out_stb_o`, `out_opnd_o` and `out_mid_o` to zero.
- R10: `out_ack_i` has no effect while `out_stb_o` is low. `out_mid_o` and `out_opnd_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| row_stb_i | input | NUM_ROWS x NUM_OPS | Per-row, per-operand ready strobes |
| row_opnd_i | input | NUM_ROWS x NUM_OPS x OP_W | Per-row operand words |
| out_ack_i | input | 1 | Consumer acknowledge |
| out_stb_o | output | 1 | Offer open |
| out_opnd_o | output | NUM_OPS x OP_W | Forwarded pair, zero while an offer is open |
| out_mid_o | output | IDX_W | Index of the last forwarded row |
| row_pend_o | output | NUM_ROWS | Per-row pending flags |

## Verification
The checker covers the following on every cycle:
- the output data being zero during an open offer;
- the offer closing one edge after an acknowledge;
- the served row's pending bit being clear afterwards;
- pending bits falling only through acceptance of that same row;
- a pending row always leading to an offer;
- the multiplex ID never moving while no offer is open;
- the reset values.

Only the bench's scenarios can show the following:
- the order in which simultaneous rows are served;
- that the forwarded words are the ones present at capture time;
- that partial strobes never capture;
- that a lower-indexed late arrival cannot preempt an open offer.

// File: rtl/oca_pkg.sv
package oca_pkg;
    typedef enum logic [0:0] {
        OFS_IDLE  = 1'b0,
        OFS_OFFER = 1'b1
    } ofs_e;
endpackage

// File: rtl/oca_row_slot.sv
module oca_row_slot #(
    parameter int NUM_OPS = 2,
    parameter int OP_W    = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic [NUM_OPS-1:0]             stb_i,
    input  logic [NUM_OPS-1:0][OP_W-1:0]   opnd_i,
    input  logic                           take_i,
    output logic                           pend_o,
    output logic [NUM_OPS-1:0][OP_W-1:0]   data_o
);
    typedef struct packed {
        logic                         pend;
        logic [NUM_OPS-1:0][OP_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.pend) begin
            if (take_i) begin
                slot_d.pend = 1'b0;
            end
        end else if (&stb_i) begin
            slot_d.pend = 1'b1;
            slot_d.data = opnd_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend_o = slot_q.pend;
    assign data_o = slot_q.data;
endmodule

// File: rtl/oca_prio_pick.sv
module oca_prio_pick #(
    parameter int NUM_ROWS = 4,
    parameter int IDX_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic [NUM_ROWS-1:0] req_i,
    output logic                vld_o,
    output logic [IDX_W-1:0]    idx_o
);
    always_comb begin
        vld_o = |req_i;
        idx_o = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/oca_out_port.sv
module oca_out_port
    import oca_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    parameter int NUM_OPS  = 2,
    parameter int OP_W     = 32,
    parameter int IDX_W    = 2
) (
    input  logic                                       clk_i,
    input  logic                                       rst_i,
    input  logic                                       pick_vld_i,
    input  logic [IDX_W-1:0]                           pick_idx_i,
    input  logic [NUM_ROWS-1:0][NUM_OPS-1:0][OP_W-1:0] row_data_i,
    input  logic                                       ack_i,
    output logic                                       out_stb_o,
    output logic [NUM_OPS-1:0][OP_W-1:0]               out_opnd_o,
    output logic [IDX_W-1:0]                           out_mid_o,
    output logic [NUM_ROWS-1:0]                        take_o
);
    typedef struct packed {
        ofs_e                         st;
        logic [IDX_W-1:0]             sel;
        logic [IDX_W-1:0]             mid;
        logic [NUM_OPS-1:0][OP_W-1:0] data;
    } outp_t;

    outp_t op_d, op_q;

    always_comb begin
        op_d   = op_q;
        take_o = '0;
        case (op_q.st)
            OFS_IDLE: begin
                if (pick_vld_i) begin
                    op_d.st   = OFS_OFFER;
                    op_d.sel  = pick_idx_i;
                    op_d.data = '0;
                end
            end
            OFS_OFFER: begin
                if (ack_i) begin
                    op_d.st            = OFS_IDLE;
                    op_d.data          = row_data_i[op_q.sel];
                    op_d.mid           = op_q.sel;
                    take_o[op_q.sel]   = 1'b1;
                end
            end
            default: op_d.st = OFS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            op_q <= '0;
        end else begin
            op_q <= op_d;
        end
    end

    assign out_stb_o  = (op_q.st == OFS_OFFER);
    assign out_opnd_o = op_q.data;
    assign out_mid_o  = op_q.mid;
endmodule

// File: rtl/opnd_collect_arb.sv
module opnd_collect_arb #(
    parameter int NUM_ROWS = 4,
    parameter int NUM_OPS  = 2,
    parameter int OP_W     = 32
) (
    input  logic                                       clk_i,
    input  logic                                       rst_i,
    input  logic [NUM_ROWS-1:0][NUM_OPS-1:0]           row_stb_i,
    input  logic [NUM_ROWS-1:0][NUM_OPS-1:0][OP_W-1:0] row_opnd_i,
    input  logic                                       out_ack_i,
    output logic                                       out_stb_o,
    output logic [NUM_OPS-1:0][OP_W-1:0]               out_opnd_o,
    output logic [((NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1)-1:0] out_mid_o,
    output logic [NUM_ROWS-1:0]                        row_pend_o
);
    localparam int IDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

    logic [NUM_ROWS-1:0]                        pend;
    logic [NUM_ROWS-1:0]                        take;
    logic [NUM_ROWS-1:0][NUM_OPS-1:0][OP_W-1:0] held;
    logic                                       pick_vld;
    logic [IDX_W-1:0]                           pick_idx;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        oca_row_slot #(
            .NUM_OPS (NUM_OPS),
            .OP_W    (OP_W)
        ) u_slot (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .stb_i   (row_stb_i[r]),
            .opnd_i  (row_opnd_i[r]),
            .take_i  (take[r]),
            .pend_o  (pend[r]),
            .data_o  (held[r])
        );
    end

    oca_prio_pick #(
        .NUM_ROWS (NUM_ROWS),
        .IDX_W    (IDX_W)
    ) u_pick (
        .req_i    (pend),
        .vld_o    (pick_vld),
        .idx_o    (pick_idx)
    );

    oca_out_port #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_OPS  (NUM_OPS),
        .OP_W     (OP_W),
        .IDX_W    (IDX_W)
    ) u_out (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pick_vld_i (pick_vld),
        .pick_idx_i (pick_idx),
        .row_data_i (held),
        .ack_i      (out_ack_i),
        .out_stb_o  (out_stb_o),
        .out_opnd_o (out_opnd_o),
        .out_mid_o  (out_mid_o),
        .take_o     (take)
    );

    assign row_pend_o = pend;
endmodule

// File: rtl/opnd_collect_arb_chk.sv
module opnd_collect_arb_chk #(
    parameter int NUM_ROWS = 4,
    parameter int NUM_OPS  = 2,
    parameter int OP_W     = 32,
    parameter int IDX_W    = 2
) (
    input logic                         clk_i,
    input logic                         rst_i,
    input logic                         out_ack_i,
    input logic                         out_stb_o,
    input logic [NUM_OPS-1:0][OP_W-1:0] out_opnd_o,
    input logic [IDX_W-1:0]             out_mid_o,
    input logic [NUM_ROWS-1:0]          row_pend_o
);
    // R9
    reset_clears_chk: assert property (@(posedge clk_i)
        rst_i |=> (row_pend_o == '0 && !out_stb_o && out_opnd_o == '0 && out_mid_o == '0));

    // R2
    pending_offers_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!out_stb_o && |row_pend_o) |=> out_stb_o);

    // R3
    offer_data_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        out_stb_o |-> (out_opnd_o == '0));

    // R4
    ack_closes_offer_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_stb_o && out_ack_i) |=> !out_stb_o);

    // R6
    served_row_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_stb_o && out_ack_i) |=> !row_pend_o[out_mid_o]);

    // R10
    idle_mid_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !out_stb_o |=> $stable(out_mid_o));

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_fall
        // R7
        pend_fall_by_accept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (!$past(rst_i) && $fell(row_pend_o[g])) |->
                ($past(out_stb_o && out_ack_i) && out_mid_o == IDX_W'(g)));
    end
endmodule

bind opnd_collect_arb opnd_collect_arb_chk #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_OPS  (NUM_OPS),
    .OP_W     (OP_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .out_ack_i  (out_ack_i),
    .out_stb_o  (out_stb_o),
    .out_opnd_o (out_opnd_o),
    .out_mid_o  (out_mid_o),
    .row_pend_o (row_pend_o)
);

// File: tb/opnd_collect_arb_tb.sv
module opnd_collect_arb_tb;
    localparam int NR = 4;
    localparam int NO = 2;
    localparam int W  = 32;
    localparam int IW = 2;
    localparam int NV = 8;
    localparam logic [NR-1:0] MASKS [NV] = '{4'b0001, 4'b0010, 4'b1001, 4'b1111,
                                             4'b0110, 4'b1000, 4'b0101, 4'b1100};

    logic clk = 1'b0;
    logic rst;
    logic [NR-1:0][NO-1:0]        row_stb;
    logic [NR-1:0][NO-1:0][W-1:0] row_opnd;
    logic                         ack;
    logic                         out_stb;
    logic [NO-1:0][W-1:0]         out_opnd;
    logic [IW-1:0]                out_mid;
    logic [NR-1:0]                pend;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    opnd_collect_arb u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .row_stb_i  (row_stb),
        .row_opnd_i (row_opnd),
        .out_ack_i  (ack),
        .out_stb_o  (out_stb),
        .out_opnd_o (out_opnd),
        .out_mid_o  (out_mid),
        .row_pend_o (pend)
    );

    function automatic logic [W-1:0] opval(input int e, input int r, input int o);
        return {8'(e), 8'(r), 8'(o), 8'hC3};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_offer(input string tag);
        int n = 0;
        while (!out_stb && n < 8) begin
            @(negedge clk);
            n++;
        end
        chk(out_stb == 1'b1, tag, 64'(out_stb), 64'd1);
    endtask

    task automatic serve_mask(input int e, input logic [NR-1:0] m);
        ack = 1'b1;
        for (int r = 0; r < NR; r++) begin
            if (m[r]) begin
                row_opnd[r][0] = opval(e, r, 0);
                row_opnd[r][1] = opval(e, r, 1);
                row_stb[r]     = 2'b11;
            end
        end
        @(negedge clk);
        chk(pend == m, "R1 pending mask after full strobes", 64'(pend), 64'(m));
        row_stb  = '0;
        row_opnd = '1;
        for (int r = 0; r < NR; r++) begin
            if (m[r]) begin
                wait_offer("R2 offer opens for pending row");
                chk(out_opnd == '0, "R3 data zero while offered", 64'(out_opnd), 64'd0);
                @(negedge clk);
                chk(out_mid == IW'(r), "R5 lowest index served in order", 64'(out_mid), 64'(r));
                chk(out_opnd == {opval(e, r, 1), opval(e, r, 0)} && !out_stb,
                    "R4 R7 R8 pair forwarded after ack", 64'(out_opnd),
                    {opval(e, r, 1), opval(e, r, 0)});
            end
        end
        @(negedge clk);
        chk(pend == '0 && !out_stb, "R6 nothing served twice", {63'd0, out_stb} | 64'(pend), 64'd0);
        ack = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [IW-1:0]      mid_save;
        logic [NO-1:0][W-1:0] dat_save;
        rst = 1'b1; row_stb = '0; row_opnd = '0; ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pend == '0 && !out_stb && out_opnd == '0 && out_mid == '0,
            "R9 reset state", 64'(out_opnd) | 64'(pend), 64'd0);
        rst = 1'b0;

        // R1: partial strobes never capture
        row_opnd[1][0] = 32'd5; row_opnd[1][1] = 32'd6;
        row_stb[1] = 2'b01;
        repeat (4) @(negedge clk);
        chk(pend == '0 && !out_stb && out_opnd == '0, "R1 strobe 01 ignored", 64'(pend), 64'd0);
        row_stb[1] = 2'b10;
        repeat (4) @(negedge clk);
        chk(pend == '0 && !out_stb && out_opnd == '0, "R1 strobe 10 ignored", 64'(pend), 64'd0);
        row_stb = '0;

        for (int e = 0; e < NV; e++) begin
            serve_mask(e, MASKS[e]);
        end

        // R3: offer held open without ack
        mid_save = out_mid;
        row_opnd[2][0] = 32'd3; row_opnd[2][1] = 32'd4; row_stb[2] = 2'b11;
        @(negedge clk);
        row_stb = '0;
        repeat (5) @(negedge clk);
        chk(out_stb == 1'b1, "R3 offer stays open", 64'(out_stb), 64'd1);
        chk(out_opnd == '0, "R3 data zero until ack", 64'(out_opnd), 64'd0);
        chk(out_mid == mid_save, "R4 id unchanged before ack", 64'(out_mid), 64'(mid_save));
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(out_mid == 2'd2 && out_opnd == {32'd4, 32'd3} && !out_stb,
            "R4 pair and id after ack", 64'(out_opnd), {32'd4, 32'd3});

        // R10: ack while idle
        dat_save = out_opnd;
        ack = 1'b1;
        repeat (3) @(negedge clk);
        ack = 1'b0;
        chk(out_mid == 2'd2 && out_opnd == dat_save && !out_stb,
            "R10 idle ack ignored", 64'(out_opnd), 64'(dat_save));

        // R5: open offer not preempted by lower row
        row_opnd[3][0] = 32'h33; row_opnd[3][1] = 32'h34; row_stb[3] = 2'b11;
        @(negedge clk);
        row_stb = '0;
        wait_offer("R2 offer for row 3");
        row_opnd[0][0] = 32'h10; row_opnd[0][1] = 32'h11; row_stb[0] = 2'b11;
        @(negedge clk);
        row_stb = '0;
        ack = 1'b1;
        @(negedge clk);
        chk(out_mid == 2'd3 && out_opnd == {32'h34, 32'h33}, "R5 locked offer row 3 served",
            64'(out_mid), 64'd3);
        wait_offer("R2 offer for row 0");
        @(negedge clk);
        ack = 1'b0;
        chk(out_mid == 2'd0 && out_opnd == {32'h11, 32'h10}, "R5 row 0 served next",
            64'(out_opnd), {32'h11, 32'h10});

        // R8: re-strobe with new data on pending row ignored
        row_opnd[1][0] = 32'hA0; row_opnd[1][1] = 32'hA1; row_stb[1] = 2'b11;
        @(negedge clk);
        row_opnd[1][0] = 32'hB0; row_opnd[1][1] = 32'hB1;
        repeat (2) @(negedge clk);
        row_stb = '0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(out_mid == 2'd1 && out_opnd == {32'hA1, 32'hA0}, "R8 captured value forwarded",
            64'(out_opnd), {32'hA1, 32'hA0});
        @(negedge clk);
        chk(pend == '0 && !out_stb, "R6 row 1 cleared", 64'(pend), 64'd0);

        // R9: reset during open offer
        row_opnd[2][0] = 32'h77; row_stb[2] = 2'b11;
        @(negedge clk);
        row_stb = '0;
        wait_offer("R2 offer before reset");
        rst = 1'b1;
        @(negedge clk);
        chk(pend == '0 && !out_stb && out_opnd == '0 && out_mid == '0,
            "R9 reset clears open offer", 64'(pend) | 64'(out_mid), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_stb && pend == '0, "R7 R9 no request survives reset", 64'(out_stb), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule